// File: doc/BRIEF.md
# Four-Lane Streaming Sum Reducer

This block adds up a stream of unsigned 32-bit elements and returns their wrapped sum. A one-cycle start pulse, with the element count on the length input, opens an operation. Elements then arrive over a valid/ready stream and are consumed one per accepted transfer.

Most of the stream is summed in four independent partial accumulators. Successive elements are dealt to the accumulators in rotation: the first element of every group of four goes to lane 0, the second to lane 1, and so on. Once the largest multiple-of-four prefix has been absorbed, one cycle folds the four partials into a single total. The leftover one to three elements are then added to that total one at a time. A one-cycle done pulse marks the result, and the sum output keeps that value until the next operation rewrites it.

Top module: `lane_sum_reducer`

## Requirements
- R1: A start pulse is accepted only while the block is idle; a start pulse during an operation is ignored and does not change its length or its result.
- R2: elem_ready_o is high only while the block is taking grouped or leftover elements; it is low after reset, while idle, during the fold cycle and during the done cycle. One element is consumed for each cycle with elem_valid_i and elem_ready_o both high.
- R3: All four partial accumulators are cleared on an accepted start, and the element at offset k (0 to 3) inside each group of four is added to accumulator k.
- R4: An operation of length L consumes exactly L elements: L with its two low bits cleared in the grouped phase, then L mod 4 in the leftover phase.
- R5: sum_o at done equals the sum of all consumed elements modulo 2^32, with unsigned wrap-around.
- R6: The fold of the partials takes exactly one cycle. When elem_valid_i stays high, done_o is high L+1 clock cycles after the edge that accepts the start.
- R7: A length of 0 yields a done pulse with sum 0 and consumes nothing. A length below 4 skips the grouped phase.
- R8: done_o is high for exactly one cycle per operation. sum_o stays unchanged from the done cycle until a later start is accepted.
- R9: After reset, done_o and elem_ready_o are 0 and sum_o is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| len_i | input | LEN_W (16) | Element count, sampled with an accepted start |
| elem_valid_i | input | 1 | Element on elem_data_i is valid |
| elem_data_i | input | DATA_W (32) | Element value |
| elem_ready_o | output | 1 | Block takes an element this cycle if valid is high |
| done_o | output | 1 | One-cycle pulse: sum_o holds the result |
| sum_o | output | DATA_W (32) | Wrapped sum of the last operation |

## Verification
The assertions assume that the producer keeps elem_data_i steady while it offers an element. They also assume that it offers no more elements than the length it announced, so the lane and partial checks see each element exactly once. The stimulus drives data only on cycles where it intends a transfer, counts accepted transfers itself, and lowers valid once L elements have gone. Stray start pulses are placed only in cycles where the block is already busy.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GROUP   = 3'd1,
    ST_COMBINE = 3'd2,
    ST_TAIL    = 3'd3,
    ST_DONE    = 3'd4
  } lsr_state_e;

endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              elem_valid_i,
  output lsr_state_e        state_o,
  output logic              elem_ready_o,
  output logic              clr_o,
  output logic              grp_take_o,
  output logic              tail_take_o,
  output logic              fold_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              done_o
);

  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [LANE_W-1:0] LANE_ONE = LANE_W'(1);

  lsr_state_e        state_q, state_d;
  logic [LEN_W-1:0]  grp_left_q, grp_left_d;
  logic [LANE_W-1:0] tail_left_q, tail_left_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              take;
  logic              accept;
  logic              grp_nonzero;

  assign elem_ready_o = (state_q == ST_GROUP) || (state_q == ST_TAIL);
  assign take         = elem_valid_i && elem_ready_o;
  assign accept       = (state_q == ST_IDLE) && start_i;
  assign grp_nonzero  = |len_i[LEN_W-1:LANE_W];

  assign clr_o       = accept;
  assign grp_take_o  = take && (state_q == ST_GROUP);
  assign tail_take_o = take && (state_q == ST_TAIL);
  assign fold_o      = (state_q == ST_COMBINE);
  assign done_o      = (state_q == ST_DONE);
  assign lane_o      = lane_q;
  assign state_o     = state_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = grp_nonzero ? ST_GROUP : ST_COMBINE;
      end
      ST_GROUP: begin
        if (take && (grp_left_q == LEN_ONE)) state_d = ST_COMBINE;
      end
      ST_COMBINE: begin
        state_d = (tail_left_q != '0) ? ST_TAIL : ST_DONE;
      end
      ST_TAIL: begin
        if (take && (tail_left_q == LANE_ONE)) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // counter next values
  always_comb begin
    grp_left_d  = grp_left_q;
    tail_left_d = tail_left_q;
    lane_d      = lane_q;
    if (accept) begin
      grp_left_d  = {len_i[LEN_W-1:LANE_W], {LANE_W{1'b0}}};
      tail_left_d = len_i[LANE_W-1:0];
      lane_d      = '0;
    end else begin
      if (grp_take_o) begin
        grp_left_d = grp_left_q - LEN_ONE;
        lane_d     = lane_q + LANE_ONE;
      end
      if (tail_take_o) tail_left_d = tail_left_q - LANE_ONE;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      grp_left_q  <= '0;
      tail_left_q <= '0;
      lane_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept || grp_take_o) begin
        grp_left_q <= grp_left_d;
        lane_q     <= lane_d;
      end
      if (accept || tail_take_o) tail_left_q <= tail_left_d;
    end
  end

endmodule

// File: rtl/lsr_lanes.sv
module lsr_lanes #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          take_i,
  input  logic [LANE_W-1:0]             lane_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [LANES-1:0][DATA_W-1:0]  part_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic              en;
    logic [DATA_W-1:0] acc_q, acc_d;

    assign en = clr_i || (take_i && (lane_i == LANE_W'(k)));

    always_comb begin
      if (clr_i) acc_d = '0;
      else       acc_d = acc_q + data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  acc_q <= '0;
      else if (en)  acc_q <= acc_d;
    end

    assign part_o[k] = acc_q;
  end

endmodule

// File: rtl/lsr_total.sv
module lsr_total #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fold_i,
  input  logic                          add_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic [LANES-1:0][DATA_W-1:0]  part_i,
  output logic [DATA_W-1:0]             total_o
);

  logic [DATA_W-1:0] folded;
  logic [DATA_W-1:0] total_q, total_d;
  logic              en;

  always_comb begin
    folded = '0;
    for (int k = 0; k < LANES; k++) folded = folded + part_i[k];
  end

  assign en = fold_i || add_i;

  always_comb begin
    if (fold_i) total_d = folded;
    else        total_d = total_q + data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  total_q <= '0;
    else if (en)  total_q <= total_d;
  end

  assign total_o = total_q;

endmodule

// File: rtl/lane_sum_reducer.sv
module lane_sum_reducer
  import lsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              elem_valid_i,
  input  logic [DATA_W-1:0] elem_data_i,
  output logic              elem_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sum_o
);

  localparam int LANE_W = $clog2(LANES);

  lsr_state_e                    state_q;
  logic                          clr;
  logic                          grp_take;
  logic                          tail_take;
  logic                          fold;
  logic [LANE_W-1:0]             lane_q;
  logic [LANES-1:0][DATA_W-1:0]  part_q;

  lsr_ctrl #(
    .LEN_W (LEN_W),
    .LANES (LANES)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .len_i        (len_i),
    .elem_valid_i (elem_valid_i),
    .state_o      (state_q),
    .elem_ready_o (elem_ready_o),
    .clr_o        (clr),
    .grp_take_o   (grp_take),
    .tail_take_o  (tail_take),
    .fold_o       (fold),
    .lane_o       (lane_q),
    .done_o       (done_o)
  );

  lsr_lanes #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .take_i (grp_take),
    .lane_i (lane_q),
    .data_i (elem_data_i),
    .part_o (part_q)
  );

  lsr_total #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_total (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fold_i  (fold),
    .add_i   (tail_take),
    .data_i  (elem_data_i),
    .part_i  (part_q),
    .total_o (sum_o)
  );

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker
  import lsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic [LEN_W-1:0]              len_i,
  input logic                          elem_valid_i,
  input logic [DATA_W-1:0]             elem_data_i,
  input logic                          elem_ready_o,
  input logic                          done_o,
  input logic [DATA_W-1:0]             sum_o,
  input lsr_state_e                    state_q,
  input logic [LANE_W-1:0]             lane_q,
  input logic [LANES-1:0][DATA_W-1:0]  part_q
);

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL && start_i && !(elem_valid_i && elem_ready_o)) |=> (state_q == ST_TAIL)); // R1

  AST_PARTS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) || state_q == ST_COMBINE || state_q == ST_DONE
    |=> $stable(part_q)); // R2

  AST_PARTS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (part_q == '0)); // R3

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_LANE_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_GROUP && elem_valid_i && elem_ready_o && lane_q == LANE_W'(k))
      |=> (part_q[k] == $past(part_q[k]) + $past(elem_data_i))); // R3
  end

  AST_FOLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMBINE) |=> (state_q != ST_COMBINE)); // R6

  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && len_i == '0) |=> (state_q == ST_COMBINE)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_GROUP || state_q == ST_DONE) |=> $stable(sum_o)); // R8

endmodule

bind lane_sum_reducer lsr_checker #(
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W),
  .LANES  (LANES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .len_i        (len_i),
  .elem_valid_i (elem_valid_i),
  .elem_data_i  (elem_data_i),
  .elem_ready_o (elem_ready_o),
  .done_o       (done_o),
  .sum_o        (sum_o),
  .state_q      (state_q),
  .lane_q       (lane_q),
  .part_q       (part_q)
);

// File: tb/lane_sum_reducer_tb.sv
`timescale 1ns/1ps
module lane_sum_reducer_tb;

  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [LEN_W-1:0]  len;
  logic              valid;
  logic [DATA_W-1:0] data;
  logic              ready;
  logic              done;
  logic [DATA_W-1:0] sum;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  lane_sum_reducer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .LANES(4)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .len_i        (len),
    .elem_valid_i (valid),
    .elem_data_i  (data),
    .elem_ready_o (ready),
    .done_o       (done),
    .sum_o        (sum)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] elem(input int pat, input int i);
    logic [31:0] x;
    x = 32'(i);
    case (pat)
      0:       return 32'hFFFF_FFFF;
      1:       return x + 32'd1;
      default: return ((x + 32'd1) * 32'h9E37_79B1) ^ (x << 7);
    endcase
  endfunction

  // one operation; gaps drop valid on some cycles; inject pulses a stray start
  task automatic run(input int L, input int pat, input bit gaps, input bit inject);
    logic [31:0] exp_sum;
    logic [31:0] held;
    int i;
    int cyc;
    bit take;
    bit hung;
    exp_sum = '0;
    i = 0;
    cyc = 0;
    hung = 0;
    @(negedge clk);
    start = 1'b1;
    len   = LEN_W'(L);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (done) break;
      if (cyc > 4 * L + 60) begin hung = 1; break; end
      if (i < L && (!gaps || ((i + cyc) % 3) != 1)) begin
        valid = 1'b1;
        data  = elem(pat, i);
      end else begin
        valid = 1'b0;
        data  = '0;
      end
      if (inject && cyc == 2) begin
        start = 1'b1;            // R1: must be ignored while busy
        len   = LEN_W'(3);
      end else begin
        start = 1'b0;
      end
      take = valid && ready;
      @(posedge clk);
      cyc++;
      if (take) begin
        exp_sum = exp_sum + data;
        i++;
      end
      @(negedge clk);
    end
    valid = 1'b0;
    start = 1'b0;
    check(!hung, "R1 done reached", 64'(hung), 64'd0);
    check(i == L, "R4 elements consumed", 64'(i), 64'(L));
    check(sum == exp_sum, "R3/R5 wrapped sum", 64'(sum), 64'(exp_sum));
    if (L == 0) check(sum == '0, "R7 zero length sum", 64'(sum), 64'd0);
    if (!gaps && !inject)
      check(cyc == L + 1, "R6 latency", 64'(cyc), 64'(L + 1));
    held = sum;
    @(posedge clk);
    @(negedge clk);
    check(!done, "R8 done single cycle", 64'(done), 64'd0);
    check(!ready, "R2 ready low when idle", 64'(ready), 64'd0);
    repeat (3) @(negedge clk);
    check(sum == held, "R8 sum holds", 64'(sum), 64'(held));
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    len   = '0;
    valid = 1'b0;
    data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done,      "R9 reset done",  64'(done),  64'd0);
    check(!ready,     "R9 reset ready", 64'(ready), 64'd0);
    check(sum == '0,  "R9 reset sum",   64'(sum),   64'd0);

    // R2: valid with no start is not consumed
    valid = 1'b1;
    data  = 32'h1234_5678;
    repeat (2) @(negedge clk);
    check(!ready, "R2 no ready while idle", 64'(ready), 64'd0);
    valid = 1'b0;

    // R4 R5 R6 R7: sweep short lengths, patterns and valid gaps
    for (int L = 0; L <= 13; L++)
      for (int pat = 0; pat < 3; pat++)
        for (int g = 0; g < 2; g++)
          run(L, pat, g[0], 1'b0);

    // R1: stray start mid-operation
    for (int L = 4; L <= 9; L++) run(L, 2, 1'b0, 1'b1);

    // long streams, wrap-around and full counter width
    run(1000, 0, 1'b0, 1'b0);
    run(65535, 2, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule